// File: doc/BRIEF.md
# Attribute Register Bank with Shared Index/Data Write Port

This block holds a small bank of display attribute registers that software reaches through a single byte-wide write port. A hidden phase flop decides what each write means. A byte written while the phase is "index" selects a register. The next byte written is stored as data into that register, and the phase then goes back to "index". Software cannot see the phase directly. To put it into a known state, software reads a separate status port. That read forces the phase back to "index", and it also returns the retrace and display-enable flags.

One register of the bank, the horizontal pixel panning value, is exported directly to the display logic. The index most recently selected is brought out on a read-back port, so the index/data sequence can be followed from outside.

Top module: `attr_port_bank`

## Requirements
- R1: After a synchronous active-high reset, the read-back index is 0x00, the panning output is 0x00, the status byte is 0x00, and the phase is "index".
- R2: Writes to the shared port alternate between index and data. A write in the index phase loads the read-back index on the next clock edge and moves the phase to data.
- R3: A write in the data phase stores the byte into the selected register, leaves the read-back index unchanged, and returns the phase to index.
- R4: A status read forces the phase to index. If a write arrives in the same cycle, the write is handled according to the phase held before that cycle, and the phase afterwards is index.
- R5: Register index 0x13 is the panning register. Its value appears on the panning output one clock after the data write; for example, index 0x13 followed by data 0x03 gives a panning value of 3.
- R6: The bank has 22 registers (indices 0x00 to 0x15). A data write to an index of 22 or above is ignored, but the phase still returns to index.
- R7: A status read captures the inputs into the status byte on the next edge: bit 3 is vertical retrace and bit 0 is display enable; all other bits are 0. The status byte holds that value until the next status read.
- R8: Data writes to any index other than 0x13 leave the panning output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the shared index/data port |
| wr_byte | input | 8 | Byte written to the shared port |
| stat_rd | input | 1 | Status port read strobe; resynchronises the phase |
| vretrace_in | input | 1 | Vertical retrace flag from the display timing |
| disp_en_in | input | 1 | Display enable flag from the display timing |
| stat_byte | output | 8 | Status byte captured by the last status read |
| index_byte | output | 8 | Currently selected index (read-back) |
| hpan | output | 8 | Horizontal pixel panning value |

## Verification
The hardest situation to reach is a desynchronised phase. This happens when a status read lands in the same cycle as a write, or in the middle of an index/data pair, so that a later byte meant as data is taken as an index. The random stimulus issues status reads independently of the writes, which produces mid-pair reads and coincident read/write cycles. It also biases index bytes toward 0x13 and toward values past the bank, so the effect shows up on the panning output. Directed sequences cover the 0x13/0x03 pair and the ignored write to index 22.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NUM_REG = 22;
  localparam int unsigned PAN_IDX = 8'h13;

  typedef enum logic {
    PH_INDEX = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;

  localparam int unsigned STAT_VR_BIT = 3;
  localparam int unsigned STAT_DE_BIT = 0;
endpackage

// File: rtl/attr_phase.sv
module attr_phase
  import attr_pkg::*;
#(
  parameter int unsigned W    = BYTE_W,
  parameter int unsigned NREG = NUM_REG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_byte,
  input  logic         stat_rd,
  output logic [W-1:0] index_q,
  output logic         data_we
);
  phase_e phase_q;
  logic   in_range;

  assign in_range = (index_q < W'(NREG));
  assign data_we  = wr_en && (phase_q == PH_DATA) && in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_INDEX;
      index_q <= '0;
    end else begin
      if (wr_en && phase_q == PH_INDEX) index_q <= wr_byte;
      if (stat_rd)
        phase_q <= PH_INDEX;
      else if (wr_en)
        phase_q <= (phase_q == PH_INDEX) ? PH_DATA : PH_INDEX;
    end
  end

  // R4: a status read always leaves the phase at index
  p_rd_forces_index_r4: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> phase_q == PH_INDEX);

  // R2: a lone write flips the phase
  p_alternate_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !stat_rd) |=> phase_q != $past(phase_q));

  // R3: a data-phase write keeps the selected index
  p_data_keeps_index_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && phase_q == PH_DATA) |=> $stable(index_q));

  // R2: an index-phase write loads the index
  p_index_load_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && phase_q == PH_INDEX) |=> index_q == $past(wr_byte));
endmodule

// File: rtl/attr_regfile.sv
module attr_regfile
  import attr_pkg::*;
#(
  parameter int unsigned W    = BYTE_W,
  parameter int unsigned NREG = NUM_REG,
  parameter int unsigned PAN  = PAN_IDX
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pan_out
);
  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && addr == W'(g))
        regs[g] <= wdata;
    end
  end

  assign pan_out = regs[PAN];

  // R5: a panning data write shows up on the output next cycle
  p_pan_load_r5: assert property (@(posedge clk) disable iff (rst)
    (we && addr == W'(PAN)) |=> pan_out == $past(wdata));

  // R8 / R6: any other write leaves the panning value alone
  p_pan_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == W'(PAN)) |=> $stable(pan_out));

  // R6: writes only ever reach existing registers
  p_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    we |-> addr < W'(NREG));
endmodule

// File: rtl/attr_status.sv
module attr_status
  import attr_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stat_rd,
  input  logic         vretrace_in,
  input  logic         disp_en_in,
  output logic [W-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else if (stat_rd) begin
      stat_q              <= '0;
      stat_q[STAT_VR_BIT] <= vretrace_in;
      stat_q[STAT_DE_BIT] <= disp_en_in;
    end
  end

  // R7: status captures the flags of the read cycle
  p_stat_capture_r7: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (stat_q[STAT_VR_BIT] == $past(vretrace_in)) &&
                (stat_q[STAT_DE_BIT] == $past(disp_en_in)) &&
                ($countones(stat_q) <= 2));

  // R7: status holds between reads
  p_stat_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> $stable(stat_q));
endmodule

// File: rtl/attr_port_bank.sv
module attr_port_bank
  import attr_pkg::*;
#(
  parameter int unsigned W    = BYTE_W,
  parameter int unsigned NREG = NUM_REG,
  parameter int unsigned PAN  = PAN_IDX
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_byte,
  input  logic         stat_rd,
  input  logic         vretrace_in,
  input  logic         disp_en_in,
  output logic [W-1:0] stat_byte,
  output logic [W-1:0] index_byte,
  output logic [W-1:0] hpan
);
  logic data_we;

  attr_phase #(.W(W), .NREG(NREG)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_byte (wr_byte),
    .stat_rd (stat_rd),
    .index_q (index_byte),
    .data_we (data_we)
  );

  attr_regfile #(.W(W), .NREG(NREG), .PAN(PAN)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (data_we),
    .addr    (index_byte),
    .wdata   (wr_byte),
    .pan_out (hpan)
  );

  attr_status #(.W(W)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .stat_rd     (stat_rd),
    .vretrace_in (vretrace_in),
    .disp_en_in  (disp_en_in),
    .stat_q      (stat_byte)
  );
endmodule

// File: tb/attr_port_bank_tb.sv
module attr_port_bank_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       stat_rd = 1'b0;
  logic       vretrace_in = 1'b0;
  logic       disp_en_in = 1'b0;
  logic [7:0] stat_byte, index_byte, hpan;

  int n_chk = 0;
  int n_fail = 0;
  bit m_data = 0;
  logic [7:0] m_idx = 0, m_pan = 0, m_stat = 0;
  string tag;

  always #5 clk = ~clk;

  attr_port_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .stat_rd(stat_rd), .vretrace_in(vretrace_in), .disp_en_in(disp_en_in),
    .stat_byte(stat_byte), .index_byte(index_byte), .hpan(hpan)
  );

  function automatic logic [7:0] stat_of(input logic vr, input logic de);
    return {4'b0, vr, 2'b0, de};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, update the model, compare at the next falling edge
  task automatic step(input bit we, input logic [7:0] wd, input bit rd,
                      input logic vr, input logic de);
    wr_en = we; wr_byte = wd; stat_rd = rd; vretrace_in = vr; disp_en_in = de;
    if (we) begin
      if (!m_data) begin
        m_idx = wd; m_data = 1;
      end else begin
        if (m_idx == 8'h13) m_pan = wd;
        m_data = 0;
      end
    end
    if (rd) begin
      m_data = 0; m_stat = stat_of(vr, de);
    end
    @(negedge clk);
    wr_en = 0; stat_rd = 0;
    chk({tag, " R2/R3 index"}, index_byte, m_idx);
    chk({tag, " R5/R6/R8 pan"}, hpan, m_pan);
    chk({tag, " R7 status"}, stat_byte, m_stat);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R1";
    chk("R1 reset index", index_byte, 8'h00);
    chk("R1 reset pan", hpan, 8'h00);
    chk("R1 reset status", stat_byte, 8'h00);

    tag = "R5 directed";
    step(1, 8'h13, 0, 0, 0);
    step(1, 8'h03, 0, 0, 0);
    chk("R5 pan equals 3", hpan, 8'h03);

    tag = "R6 directed";
    step(1, 8'd22, 0, 0, 0);
    step(1, 8'h3f, 0, 0, 0);
    step(1, 8'h13, 0, 0, 0);         // must be an index: toggle returned
    chk("R6 toggle back to index", index_byte, 8'h13);
    step(1, 8'h07, 0, 0, 0);
    chk("R6 pan after recovery", hpan, 8'h07);

    tag = "R4 directed";
    step(1, 8'h13, 0, 0, 0);         // now in data phase
    step(0, 8'h00, 1, 1, 0);         // resync mid-pair
    chk("R7 vretrace bit3", stat_byte, 8'h08);
    step(1, 8'h02, 0, 0, 0);         // taken as index
    chk("R4 resync makes index", index_byte, 8'h02);
    step(1, 8'h55, 0, 0, 0);
    chk("R8 other index keeps pan", hpan, 8'h07);
    step(1, 8'h13, 1, 0, 1);         // coincident write and read
    step(1, 8'h13, 0, 0, 0);         // phase index again
    step(1, 8'h09, 0, 0, 0);
    chk("R4 coincident read/write", hpan, 8'h09);

    tag = "random";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] b;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 4) b = 8'h13;
      else if (sel < 6) b = 8'(22 + $urandom_range(0, 10));
      else b = 8'($urandom);
      step($urandom_range(0, 3) != 0, b, $urandom_range(0, 5) == 0,
           1'($urandom), 1'($urandom));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule